// File: doc/BRIEF.md
# Predicated SIMD Functional Unit

This block is one 64-bit issue slot of a coarse-grained processing array. Each cycle it can accept one operation: a 5-bit opcode, two 64-bit operands and an input predicate. It returns a 64-bit result, a result-valid strobe and a predicate flag. Scalar arithmetic, logic, shifts and compares finish in one cycle. The four-lane 16-bit SIMD add, subtract and shift operations also finish in one cycle. The 16-bit integer multiplies and the two-lane complex Q15 multiply take three cycles and are fully pipelined.

The schedule is static, so no handshake exists. An operation whose predicate is false leaves no trace at the output. The compiler is expected to avoid placing a single-cycle result in the same cycle as a multiply result. If that happens anyway, the multiply keeps the result port. Operands of the unused path are forced to zero so that idle logic stays quiet.

Timing convention: an operation with latency L is sampled at rising edge k. Its result is visible after edge k+L-1, so it can be sampled just before edge k+L.

Top module: `simd_fu64`

## Requirements
- R1: A result is produced only for an operation with `issue_i`=1 and `pred_i`=1. When `pred_i`=0, nothing reaches the output, and this includes multiplies. `pred_i` has no effect while `issue_i`=0.
- R2: Scalar operations have latency 1. The opcodes are: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 shift left logical and 6 shift right logical, with the shift amount taken from `b_i[5:0]`. Opcodes 17 to 31 give a valid zero result.
- R3: The compares have latency 1. They are 7 equal, 8 signed less-than and 9 unsigned less-than. A compare returns `res_o` = 64'd0 or 64'd1 and raises `flag_o` equal to the outcome. `flag_o` is 0 for every other opcode and whenever `res_o` is not valid.
- R4: SIMD add (10) and subtract (11) work on four 16-bit lanes (lane n = bits 16n+15..16n). Each lane wraps modulo 2^16, and no carry passes between lanes. Latency is 1.
- R5: SIMD shift left logical (12) and SIMD shift right arithmetic (13) shift each lane of A by bits [3:0] of the same lane of B. Latency is 1.
- R6: Signed multiply (14) and unsigned multiply (15) form the product of `a_i[15:0]` and `b_i[15:0]`. The 32-bit product is sign-extended (signed) or zero-extended (unsigned) to 64 bits. Latency is 3.
- R7: Complex multiply (16) treats each 32-bit half as one complex value, with the real part in the low 16 bits and the imaginary part in the high 16 bits, both in Q15. Each output part is computed as (exact sum of products + 2^14) shifted arithmetically right by 15, then saturated to the range -32768..32767. Latency is 3.
- R8: A new multiply can be accepted every cycle. Back-to-back multiplies each emerge exactly three cycles after issue.
- R9: When a predicated-true multiply result and a single-cycle result fall in the same output cycle, the multiply result is delivered and the single-cycle result is discarded. A multiply with a false predicate never displaces a single-cycle result.
- R10: Reset (`rst_n`=0, asynchronous) clears `res_o`, `res_vld_o` and `flag_o` to zero. Whenever `res_vld_o`=0, `res_o` and `flag_o` are also zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | An operation is presented this cycle |
| op_i | input | 5 | Opcode |
| pred_i | input | 1 | Input predicate of the operation |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| res_o | output | 64 | Result, zero when not valid |
| res_vld_o | output | 1 | Result valid |
| flag_o | output | 1 | Predicate produced by a compare |

## Verification
Two functions can land in the same cycle: the three-stage multiply write-back and the one-cycle fast write-back. The bench provokes this on purpose by issuing a single-cycle operation two cycles after a multiply. It then expects the multiply value at the port and no trace of the fast result. The same spacing is also issued behind a multiply with a false predicate, and there the fast result must appear. In the random phase, the bench keeps a per-cycle expectation ring that applies the same rule, so every accidental overlap is judged the same way.

// File: rtl/simd_fu64.sv
module simd_fu64 #(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue_i,
  input  logic [4:0]             op_i,
  input  logic                   pred_i,
  input  logic [LANES*16-1:0]    a_i,
  input  logic [LANES*16-1:0]    b_i,
  output logic [LANES*16-1:0]    res_o,
  output logic                   res_vld_o,
  output logic                   flag_o
);
  localparam int LW  = 16;
  localparam int W   = LANES * LW;
  localparam int PW  = 2 * LW;
  localparam int NCX = LANES / 2;
  localparam int SW  = $clog2(W);
  localparam int LSW = $clog2(LW);
  localparam logic signed [PW+1:0] RND  = 1 <<< (LW - 2);
  localparam logic signed [PW+1:0] MAXP = (1 <<< (LW - 1)) - 1;
  localparam logic signed [PW+1:0] MINN = -(1 <<< (LW - 1));

  localparam logic [4:0] OP_ADD = 5'd0,  OP_SUB = 5'd1,  OP_AND = 5'd2,  OP_OR = 5'd3;
  localparam logic [4:0] OP_XOR = 5'd4,  OP_SHL = 5'd5,  OP_SHR = 5'd6;
  localparam logic [4:0] OP_CEQ = 5'd7,  OP_CLT = 5'd8,  OP_CLTU = 5'd9;
  localparam logic [4:0] OP_VADD = 5'd10, OP_VSUB = 5'd11, OP_VSHL = 5'd12, OP_VSRA = 5'd13;
  localparam logic [4:0] OP_MULS = 5'd14, OP_MULU = 5'd15, OP_CMUL = 5'd16;

  logic fire, is_mul, is_cmp;
  assign fire   = issue_i & pred_i;
  assign is_mul = (op_i == OP_MULS) | (op_i == OP_MULU) | (op_i == OP_CMUL);
  assign is_cmp = (op_i == OP_CEQ) | (op_i == OP_CLT) | (op_i == OP_CLTU);

  logic [W-1:0] fa, fb, ma, mb;
  assign fa = (fire & ~is_mul) ? a_i : '0;
  assign fb = (fire & ~is_mul) ? b_i : '0;
  assign ma = (fire &  is_mul) ? a_i : '0;
  assign mb = (fire &  is_mul) ? b_i : '0;

  logic [W-1:0] vadd, vsub, vshl, vsra;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] la, lb;
    assign la = fa[l*LW +: LW];
    assign lb = fb[l*LW +: LW];
    assign vadd[l*LW +: LW] = la + lb;
    assign vsub[l*LW +: LW] = la - lb;
    assign vshl[l*LW +: LW] = la << lb[LSW-1:0];
    assign vsra[l*LW +: LW] = $signed(la) >>> lb[LSW-1:0];
  end

  logic [W-1:0] fast_res;
  logic         fast_flag;
  always_comb begin
    fast_res  = '0;
    fast_flag = 1'b0;
    case (op_i)
      OP_ADD:  fast_res = fa + fb;
      OP_SUB:  fast_res = fa - fb;
      OP_AND:  fast_res = fa & fb;
      OP_OR:   fast_res = fa | fb;
      OP_XOR:  fast_res = fa ^ fb;
      OP_SHL:  fast_res = fa << fb[SW-1:0];
      OP_SHR:  fast_res = fa >> fb[SW-1:0];
      OP_CEQ:  fast_flag = (fa == fb);
      OP_CLT:  fast_flag = ($signed(fa) < $signed(fb));
      OP_CLTU: fast_flag = (fa < fb);
      OP_VADD: fast_res = vadd;
      OP_VSUB: fast_res = vsub;
      OP_VSHL: fast_res = vshl;
      OP_VSRA: fast_res = vsra;
      default: ;
    endcase
    if (is_cmp) fast_res = {{(W-1){1'b0}}, fast_flag};
  end

  logic signed [LW:0]   sa, sb;
  logic signed [PW-1:0] sprod;
  logic [W-1:0]         s_ext;
  assign sa    = {(op_i == OP_MULS) & ma[LW-1], ma[LW-1:0]};
  assign sb    = {(op_i == OP_MULS) & mb[LW-1], mb[LW-1:0]};
  assign sprod = sa * sb;
  assign s_ext = (op_i == OP_MULS) ? {{(W-PW){sprod[PW-1]}}, sprod}
                                   : {{(W-PW){1'b0}}, sprod};

  logic [NCX-1:0][3:0][PW-1:0] prod_c, m1_p;
  for (genvar c = 0; c < NCX; c++) begin : g_cprod
    logic signed [LW-1:0] ar, ai, br, bi;
    assign ar = ma[c*PW +: LW];
    assign ai = ma[c*PW+LW +: LW];
    assign br = mb[c*PW +: LW];
    assign bi = mb[c*PW+LW +: LW];
    assign prod_c[c][0] = ar * br;
    assign prod_c[c][1] = ai * bi;
    assign prod_c[c][2] = ar * bi;
    assign prod_c[c][3] = ai * br;
  end

  logic         m1_vld, m1_cpx, m2_vld;
  logic [W-1:0] m1_s, m2_res, cpx_res;

  function automatic logic [LW-1:0] q15(input logic signed [PW+1:0] x);
    logic signed [PW+1:0] r;
    r = (x + RND) >>> (LW - 1);
    if (r > MAXP)      q15 = MAXP[LW-1:0];
    else if (r < MINN) q15 = MINN[LW-1:0];
    else               q15 = r[LW-1:0];
  endfunction

  for (genvar c = 0; c < NCX; c++) begin : g_cacc
    logic signed [PW+1:0] re, im;
    assign re = $signed(m1_p[c][0]) - $signed(m1_p[c][1]);
    assign im = $signed(m1_p[c][2]) + $signed(m1_p[c][3]);
    assign cpx_res[c*PW +: LW]    = q15(re);
    assign cpx_res[c*PW+LW +: LW] = q15(im);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_vld    <= 1'b0;
      m1_cpx    <= 1'b0;
      m1_s      <= '0;
      m1_p      <= '0;
      m2_vld    <= 1'b0;
      m2_res    <= '0;
      res_o     <= '0;
      res_vld_o <= 1'b0;
      flag_o    <= 1'b0;
    end else begin
      m1_vld    <= fire & is_mul;
      m1_cpx    <= op_i == OP_CMUL;
      m1_s      <= s_ext;
      m1_p      <= prod_c;
      m2_vld    <= m1_vld;
      m2_res    <= m1_cpx ? cpx_res : m1_s;
      res_o     <= m2_vld ? m2_res : ((fire & ~is_mul) ? fast_res : '0);
      res_vld_o <= m2_vld | (fire & ~is_mul);
      flag_o    <= ~m2_vld & fire & is_cmp & fast_flag;
    end
  end

  a_r1_pred_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !pred_i && !m2_vld) |=> !res_vld_o);
  a_r2_fast_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_mul && !m2_vld) |=> res_vld_o);
  a_r6_mul_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_mul) |=> ##2 res_vld_o);
  a_r9_mul_wins: assert property (@(posedge clk) disable iff (!rst_n)
    m2_vld |=> (res_vld_o && !flag_o));
  a_r3_flag_shape: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o |-> (res_vld_o && res_o == {{(W-1){1'b0}}, 1'b1}));
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_o |-> (res_o == '0 && !flag_o));
endmodule

// File: tb/simd_fu64_test.sv
`timescale 1ns/1ps
module simd_fu64_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic        pred_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [63:0] res_o;
  logic        res_vld_o, flag_o;

  simd_fu64 uut (.clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i), .pred_i(pred_i),
                 .a_i(a_i), .b_i(b_i), .res_o(res_o), .res_vld_o(res_vld_o), .flag_o(flag_o));

  always #2 clk = ~clk;

  int checks = 0, bad = 0, e = 0;
  bit done = 0;
  logic        ev[8], ef[8], em[8];
  logic [63:0] er[8];
  string       et[8];

  function automatic bit mul_op(input logic [4:0] op);
    return op == 5'd14 || op == 5'd15 || op == 5'd16;
  endfunction

  function automatic void ref_fast(input logic [4:0] op, input logic [63:0] a, b,
                                   output logic [63:0] r, output logic f);
    r = '0; f = 1'b0;
    case (op)
      5'd0: r = a + b;
      5'd1: r = a - b;
      5'd2: r = a & b;
      5'd3: r = a | b;
      5'd4: r = a ^ b;
      5'd5: r = a << b[5:0];
      5'd6: r = a >> b[5:0];
      5'd7: f = (a == b);
      5'd8: f = ($signed(a) < $signed(b));
      5'd9: f = (a < b);
      5'd10, 5'd11, 5'd12, 5'd13:
        for (int l = 0; l < 4; l++) begin
          int x, y, s, v;
          x = int'(a[16*l +: 16]);
          y = int'(b[16*l +: 16]);
          s = y & 15;
          if (op == 5'd10)      v = x + y;
          else if (op == 5'd11) v = x - y;
          else if (op == 5'd12) v = x << s;
          else begin
            if (x >= 32768) x = x - 65536;
            v = x >>> s;
          end
          r[16*l +: 16] = v[15:0];
        end
      default: ;
    endcase
    if (op >= 5'd7 && op <= 5'd9) r = {63'd0, f};
  endfunction

  function automatic logic [15:0] sat16(input longint v);
    longint q;
    q = (v + 16384) >>> 15;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q[15:0];
  endfunction

  function automatic logic [63:0] ref_mul(input logic [4:0] op, input logic [63:0] a, b);
    logic [63:0] r;
    longint p;
    r = '0;
    if (op == 5'd14) begin
      p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
      r = p;
    end else if (op == 5'd15) begin
      p = longint'(a[15:0]) * longint'(b[15:0]);
      r = p;
    end else
      for (int k = 0; k < 2; k++) begin
        longint ar, ai, br, bi;
        ar = longint'($signed(a[32*k +: 16]));
        ai = longint'($signed(a[32*k+16 +: 16]));
        br = longint'($signed(b[32*k +: 16]));
        bi = longint'($signed(b[32*k+16 +: 16]));
        r[32*k +: 16]    = sat16(ar*br - ai*bi);
        r[32*k+16 +: 16] = sat16(ar*bi + ai*br);
      end
    return r;
  endfunction

  task automatic step(input logic iss, input logic [4:0] op, input logic [63:0] a, b,
                      input logic p, input string tag);
    int i, nf, nm;
    logic [63:0] r;
    logic f;
    @(negedge clk);
    i = e % 8;
    checks++;
    if (res_vld_o !== ev[i] ||
        (ev[i] && (res_o !== er[i] || flag_o !== ef[i])) ||
        (!ev[i] && (res_o !== 64'd0 || flag_o !== 1'b0))) begin
      bad++;
      $display("FAIL %s: got vld=%b res=%h flag=%b, expected vld=%b res=%h flag=%b",
               ev[i] ? et[i] : "R1", res_vld_o, res_o, flag_o, ev[i], ev[i] ? er[i] : 64'd0,
               ev[i] ? ef[i] : 1'b0);
    end
    ev[i] = 0; em[i] = 0; ef[i] = 0; er[i] = '0;
    issue_i = iss; op_i = op; a_i = a; b_i = b; pred_i = p;
    nf = (e + 1) % 8;
    nm = (e + 3) % 8;
    if (iss && p) begin
      if (mul_op(op)) begin
        ev[nm] = 1; em[nm] = 1; ef[nm] = 0; er[nm] = ref_mul(op, a, b); et[nm] = tag;
      end else if (!(ev[nf] && em[nf])) begin
        ref_fast(op, a, b, r, f);
        ev[nf] = 1; em[nf] = 0; ef[nf] = f; er[nf] = r; et[nf] = tag;
      end
    end
    e++;
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 6)
      0: return 64'h8000_8000_8000_8000;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h7FFF_7FFF_7FFF_7FFF;
      3: return {48'd0, 16'($urandom)};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #800000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin ev[i] = 0; ef[i] = 0; em[i] = 0; er[i] = '0; et[i] = ""; end
    repeat (3) @(negedge clk);
    checks++;
    if (res_o !== 64'd0 || res_vld_o !== 1'b0 || flag_o !== 1'b0) begin
      bad++;
      $display("FAIL R10: reset got res=%h vld=%b flag=%b, expected 0 0 0", res_o, res_vld_o, flag_o);
    end
    rst_n = 1'b1;

    step(1, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1, "R2");
    step(1, 5'd5, 64'h1, 64'hFFC0_0000_0000_003F, 1, "R2");
    step(1, 5'd6, 64'h8000_0000_0000_0000, 64'd4, 1, "R2");
    step(1, 5'd20, 64'h1234, 64'h5678, 1, "R2");
    step(1, 5'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1, "R3");
    step(1, 5'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1, "R3");
    step(1, 5'd7, 64'hABCD, 64'hABCD, 1, "R3");
    step(1, 5'd10, 64'hFFFF_7FFF_FFFF_0001, 64'h0001_0001_0001_FFFF, 1, "R4");
    step(1, 5'd11, 64'h0000_8000_0000_0005, 64'h0001_0001_0001_0007, 1, "R4");
    step(1, 5'd13, 64'h8000_8000_4000_8000, 64'h000F_0013_0001_0000, 1, "R5");
    step(1, 5'd12, 64'h0001_0001_FFFF_0001, 64'h000F_0010_0004_0023, 1, "R5");
    step(1, 5'd14, 64'h8000, 64'h7FFF, 1, "R6");
    step(1, 5'd15, 64'hFFFF, 64'hFFFF, 1, "R6");
    step(1, 5'd16, 64'h0000_8000_0000_8000, 64'h0000_8000_8000_8000, 1, "R7");
    step(1, 5'd16, 64'h4000_4000_C000_2000, 64'h2000_4000_7FFF_0001, 1, "R7");
    step(0, 5'd0, '0, '0, 1, "R1");
    step(1, 5'd14, 64'h0003, 64'h0005, 1, "R8");
    step(1, 5'd14, 64'hFFFF, 64'h0002, 1, "R8");
    step(1, 5'd15, 64'h8000, 64'h0002, 1, "R8");
    step(1, 5'd16, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1, "R8");
    step(0, 5'd0, '0, '0, 0, "R1");
    step(0, 5'd0, '0, '0, 0, "R1");
    step(1, 5'd16, 64'h1000_2000_3000_4000, 64'h0100_0200_0300_0400, 1, "R9");
    step(1, 5'd0, 64'd10, 64'd20, 1, "R9");
    step(1, 5'd4, 64'hDEAD, 64'hBEEF, 1, "R9");
    step(1, 5'd7, 64'd1, 64'd1, 1, "R9");
    step(1, 5'd15, 64'h7777, 64'h2222, 0, "R1");
    step(1, 5'd1, 64'd50, 64'd8, 1, "R1");
    step(1, 5'd7, 64'd3, 64'd3, 1, "R9");
    step(1, 5'd0, 64'd1, 64'd1, 0, "R1");
    step(0, 5'd7, 64'd0, 64'd0, 1, "R1");
    repeat (4) step(0, 5'd0, '0, '0, 0, "R1");

    for (int n = 0; n < 4000; n++) begin
      logic [4:0] op;
      logic [63:0] a, b;
      string tg;
      op = 5'($urandom_range(0, 20));
      a = pick();
      b = pick();
      if (op <= 5'd6 || op > 5'd16) tg = "R2";
      else if (op <= 5'd9)  tg = "R3";
      else if (op <= 5'd11) tg = "R4";
      else if (op <= 5'd13) tg = "R5";
      else if (op <= 5'd15) tg = "R6";
      else                  tg = "R7";
      step(($urandom % 8) != 0, op, a, b, ($urandom % 4) != 0, tg);
    end
    repeat (4) step(0, 5'd0, '0, '0, 0, "R1");

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule